// File: doc/BRIEF.md
# SPI Slave Channel Controller

This block is the slave side of a serial peripheral link. It serves a single external master, and that master supplies the serial clock, so the master alone sets the bit rate. Inside the block there is one shift register. A transmit holding register feeds it, and a receive holding register takes complete words from it. Two status flags and two DMA request lines report the state of the holding registers. The serial pins are brought into a faster system clock through two-flop synchronizers, and clock edges are found by edge detection in that domain. For this reason the serial clock must stay well below the system clock; a half period of at least four system cycles is needed.

Software talks to the block through a small register port with four word addresses: configuration, transmit, receive and status. The configuration sets the channel enable, the transfer direction, the word length (4 to 32 bits), the select polarity, the clock idle level and the clock phase. It can also turn the chip-select off so that words are framed only by counting clock edges. When a selection begins, the transmit word is always copied into the shift register, even if software has not rewritten it. Words may follow one another with no idle clock between them.

Top module: `spis_channel`

## Requirements
- R1: After reset the status register (address 3) reads 0x1: bit 0 (transmit-empty) is set and bit 1 (receive-full) is clear. Both DMA requests and the data output enable are low.
- R2: While configuration bit 0 (enable) is clear, a whole frame from the master leaves the status unchanged and keeps the output enable low.
- R3: In full-duplex mode the master receives the transmit holding word. The receive register (address 2) gets the word the master shifted in.
- R4: Configuration bits [7:3] hold the word length minus one, for lengths from 4 to 32 bits. Bits travel most significant first, on both data lines.
- R5: Bit 9 sets the clock idle level and bit 10 sets the phase. The slave samples on the rising clock edge when the two bits are equal and on the falling edge otherwise, so all four clock modes work.
- R6: Each new selection copies the transmit holding register into the shift register even when it was not rewritten. The same word is then sent again.
- R7: A write to address 1 clears transmit-empty, and a copy into the shift register sets it again. A completed word sets receive-full, and a read of address 2 clears it.
- R8: Bits [2:1] select the mode: 0 full duplex, 1 transmit only, 2 receive only, 3 same as 0. Transmit only leaves the receive register and receive-full untouched. Receive only keeps the output enable low and leaves transmit-empty untouched.
- R9: Bit 8 sets the select polarity: 1 means active high and 0 means active low.
- R10: With bit 11 set, the select input is ignored. The channel counts as selected whenever it is enabled, and words are framed only by counting clock edges.
- R11: Words can follow one another with no idle clock. A transmit word written before the last bit of the current word is sent as the next word.
- R12: The write DMA request (enabled by bit 13) follows transmit-empty and drops after a transmit write. The read DMA request (enabled by bit 12) follows receive-full and drops after a receive read. Both stay low while their enable bit is clear.
- R13: If select is released partway through a word, the partial word is thrown away and the bit count restarts at the next selection.
- R14: If a word completes in the same cycle as a host read of the receive register, receive-full ends set. The read returns the previous word, and the register then holds the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (needed for the receive-read side effect) |
| host_addr | input | 2 | Register word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs | input | 1 | Select from the master, polarity set by software |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| dma_rd_req | output | 1 | Read DMA request |
| dma_wr_req | output | 1 | Write DMA request |

## Verification
Two events can land in the same system cycle: a word completing from the serial side, and the host reading the receive register. The bench provokes this by raising the read strobe exactly two system cycles after it drives the last sampling clock edge. That is the cycle in which the synchronized edge reaches the shift engine. The collision passes if the read data shows the earlier word, receive-full stays set afterwards, and a later read returns the newer word.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int ADDR_W = 2;
  localparam int MIN_BITS = 4;

  typedef enum logic [1:0] {
    XFER_DUPLEX = 2'd0,
    XFER_TXONLY = 2'd1,
    XFER_RXONLY = 2'd2,
    XFER_ALT    = 2'd3
  } xfer_mode_e;

  // packed from MSB: bit 13 down to bit 0
  typedef struct packed {
    logic             dma_wr_en;
    logic             dma_rd_en;
    logic             free_run;
    logic             cpha;
    logic             cpol;
    logic             sel_hi;
    logic [LEN_W-1:0] len_m1;
    xfer_mode_e       mode;
    logic             enable;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_TX   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RX   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output chan_cfg_t         cfg,
  output logic [DATA_W-1:0] tx_hold,
  input  logic              tx_take,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              dma_rd_req,
  output logic              dma_wr_req
);
  chan_cfg_t         cfg_q, cfg_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              txe_q, txe_d, rxf_q, rxf_d;
  logic              wr_cfg, wr_tx, rd_rx, rx_used, rx_load;

  assign wr_cfg  = host_wr && (host_addr == A_CFG);
  assign wr_tx   = host_wr && (host_addr == A_TX);
  assign rd_rx   = host_rd && (host_addr == A_RX);
  assign rx_used = (cfg_q.mode != XFER_TXONLY);
  assign rx_load = rx_done && rx_used;

  always_comb begin
    cfg_d = wr_cfg ? chan_cfg_t'(host_wdata[CFG_W-1:0]) : cfg_q;
    tx_d  = wr_tx ? host_wdata : tx_q;
    // host write wins over a same-cycle copy into the shifter
    if (wr_tx)        txe_d = 1'b0;
    else if (tx_take) txe_d = 1'b1;
    else              txe_d = txe_q;
    rx_d  = rx_load ? rx_word : rx_q;
    // a completing word wins over a same-cycle host read
    if (rx_load)      rxf_d = 1'b1;
    else if (rd_rx)   rxf_d = 1'b0;
    else              rxf_d = rxf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      txe_q <= 1'b1;
      rxf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      txe_q <= txe_d;
      rxf_q <= rxf_d;
    end
  end

  always_comb begin
    unique case (host_addr)
      A_CFG:   host_rdata = DATA_W'(cfg_q);
      A_TX:    host_rdata = tx_q;
      A_RX:    host_rdata = rx_q;
      default: host_rdata = {{(DATA_W-2){1'b0}}, rxf_q, txe_q};
    endcase
  end

  assign cfg        = cfg_q;
  assign tx_hold    = tx_q;
  assign dma_wr_req = cfg_q.dma_wr_en & txe_q;
  assign dma_rd_req = cfg_q.dma_rd_en & rxf_q;

  // R7
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !txe_q);
  // R6
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !wr_tx) |=> txe_q);
  // R7
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_load) |=> !rxf_q);
  // R14
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (rxf_q && rx_q == $past(rx_word)));
  // R12
  dma_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !dma_wr_req);
endmodule

// File: rtl/spis_shift.sv
module spis_shift
  import spis_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [DATA_W-1:0] tx_hold,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  output logic              miso,
  output logic              miso_oe,
  output logic              tx_take,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [LEN_W-1:0] MIN_M1 = LEN_W'(MIN_BITS - 1);
  localparam logic [LEN_W-1:0] TOP_M1 = LEN_W'(DATA_W - 1);

  logic              sclk_q, sel_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]  top_idx;
  logic              sel, sel_rise, samp, last, tx_used;
  logic [DATA_W-1:0] shifted, fill, mask;

  assign top_idx  = (cfg.len_m1 < MIN_M1) ? MIN_M1 : cfg.len_m1;
  assign tx_used  = (cfg.mode != XFER_RXONLY);
  assign sel      = cfg.enable & (cfg.free_run | (cs_s == cfg.sel_hi));
  assign sel_rise = sel & ~sel_q;
  assign samp     = sel & ~sel_rise & (sclk_s != sclk_q)
                  & (sclk_s == ~(cfg.cpol ^ cfg.cpha));
  assign last     = samp & (cnt_q == top_idx);
  assign shifted  = {sh_q[DATA_W-2:0], mosi_s};
  assign fill     = tx_used ? tx_hold : '0;
  assign mask     = {DATA_W{1'b1}} >> (TOP_M1 - top_idx);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!sel) begin
      cnt_d = '0;
    end else if (sel_rise || last) begin
      sh_d  = fill;
      cnt_d = '0;
    end else if (samp) begin
      sh_d  = shifted;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  assign tx_take = (sel_rise | last) & tx_used;
  assign rx_done = last;
  assign rx_word = shifted & mask;
  assign miso    = sh_q[top_idx];
  assign miso_oe = sel_q & tx_used;

  // R13
  deselect_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0));
  // R11
  word_end_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && tx_used) |=> (sh_q == $past(tx_hold)));
endmodule

// File: rtl/spis_channel.sv
module spis_channel
  import spis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              dma_rd_req,
  output logic              dma_wr_req
);
  logic [1:0]        rst_pipe;
  logic              rst_ni;
  logic [2:0]        pins_s;
  chan_cfg_t         cfg;
  logic [DATA_W-1:0] tx_hold, rx_word;
  logic              tx_take, rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     ({spi_sclk, spi_cs, spi_mosi}),
    .q     (pins_s)
  );

  spis_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cfg        (cfg),
    .tx_hold    (tx_hold),
    .tx_take    (tx_take),
    .rx_done    (rx_done),
    .rx_word    (rx_word),
    .dma_rd_req (dma_rd_req),
    .dma_wr_req (dma_wr_req)
  );

  spis_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cfg     (cfg),
    .tx_hold (tx_hold),
    .sclk_s  (pins_s[2]),
    .cs_s    (pins_s[1]),
    .mosi_s  (pins_s[0]),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe),
    .tx_take (tx_take),
    .rx_done (rx_done),
    .rx_word (rx_word)
  );
endmodule

// File: tb/spis_channel_bench.sv
module spis_channel_bench;
  import spis_pkg::*;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        spi_sclk = 1'b0, spi_cs = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe, dma_rd_req, dma_wr_req;
  logic [31:0] coll_data;
  int          checks = 0, fails = 0, oe_cnt = 0;
  bit          finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (spi_miso_oe) oe_cnt++;

  spis_channel u_spis_channel (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(bit en, int mode, int bits, bit selhi, bit cpol,
                                       bit cpha, bit free, bit dr, bit dw);
    return {18'd0, dw, dr, free, cpha, cpol, selhi, 5'(bits - 1), 2'(mode), en};
  endfunction

  function automatic logic [31:0] maskn(int bits);
    return (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  // master side of one word; the master samples spi_miso at its sampling edge
  task automatic spi_word(input logic [31:0] mo, input int bits, input bit cpol, input bit cpha,
                          input bit collide, output logic [31:0] mi);
    mi = '0;
    for (int b = bits - 1; b >= 0; b--) begin
      if (!cpha) begin
        spi_mosi = mo[b];
        repeat (H) @(negedge clk);
        spi_sclk = ~cpol; mi = {mi[30:0], spi_miso};
        if (collide && b == 0) begin
          @(negedge clk); @(negedge clk);
          host_rd = 1'b1; host_addr = A_RX; #1 coll_data = host_rdata;
          @(negedge clk); host_rd = 1'b0;
          repeat (H - 3) @(negedge clk);
        end else repeat (H) @(negedge clk);
        spi_sclk = cpol;
      end else begin
        repeat (H) @(negedge clk);
        spi_sclk = ~cpol; spi_mosi = mo[b];
        repeat (H) @(negedge clk);
        spi_sclk = cpol; mi = {mi[30:0], spi_miso};
      end
    end
  endtask

  task automatic xfer(input logic [31:0] mo, input int bits, input bit cpol, input bit cpha,
                      input bit selhi, input bit collide, output logic [31:0] mi);
    spi_cs = selhi;
    repeat (6) @(negedge clk);
    spi_word(mo, bits, cpol, cpha, collide, mi);
    repeat (H) @(negedge clk);
    spi_cs = ~selhi;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, mi, mi2, txw, mow;
    int oe0;
    int bl [4] = '{8, 4, 32, 13};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(A_STAT, rd);
    check(rd == 32'h1, "R1 status after reset", rd, 32'h1);
    check({dma_rd_req, dma_wr_req, spi_miso_oe} == 3'b000, "R1 dma/oe after reset",
          {dma_rd_req, dma_wr_req, spi_miso_oe}, 0);

    // R2 disabled channel ignores a frame
    hwrite(A_CFG, cfgw(0, 0, 8, 0, 0, 0, 0, 0, 0));
    oe0 = oe_cnt;
    xfer(32'h5A, 8, 0, 0, 0, 0, mi);
    hread(A_STAT, rd);
    check(rd == 32'h1, "R2 status unchanged when disabled", rd, 32'h1);
    check(oe_cnt == oe0, "R2 output enable stays low", oe_cnt, oe0);

    // R3 R4 R5 four clock modes with several lengths
    for (int m = 0; m < 4; m++) begin
      txw = 32'hC3A5_96E1 ^ (32'h1111_1111 * m);
      mow = 32'h5A0F_F0A5 ^ (32'h0F0F_3333 * m);
      hwrite(A_CFG, cfgw(0, 0, bl[m], 0, m[1], m[0], 0, 0, 0));
      spi_sclk = m[1];
      hwrite(A_TX, txw);
      hwrite(A_CFG, cfgw(1, 0, bl[m], 0, m[1], m[0], 0, 0, 0));
      xfer(mow, bl[m], m[1], m[0], 0, 0, mi);
      check(mi == (txw & maskn(bl[m])), $sformatf("R3 R4 R5 master word mode %0d", m),
            mi, txw & maskn(bl[m]));
      hread(A_STAT, rd);
      check(rd == 32'h3, "R7 both flags after word", rd, 32'h3);
      hread(A_RX, rd);
      check(rd == (mow & maskn(bl[m])), $sformatf("R3 R4 R5 slave word mode %0d", m),
            rd, mow & maskn(bl[m]));
      hread(A_STAT, rd);
      check(rd == 32'h1, "R7 receive read clears flag", rd, 32'h1);
    end

    // R6 reload without rewrite (mode 3, 13 bits, last txw)
    xfer(32'h0ABC, 13, 1, 1, 0, 0, mi);
    check(mi == (txw & maskn(13)), "R6 unchanged word resent", mi, txw & maskn(13));
    hread(A_RX, rd);

    // R9 active-high select
    hwrite(A_CFG, cfgw(0, 0, 8, 1, 0, 0, 0, 0, 0));
    spi_sclk = 1'b0; spi_cs = 1'b0;
    hwrite(A_TX, 32'h96);
    hwrite(A_CFG, cfgw(1, 0, 8, 1, 0, 0, 0, 0, 0));
    xfer(32'h3C, 8, 0, 0, 1, 0, mi);
    check(mi == 32'h96, "R9 active-high select master word", mi, 32'h96);
    hread(A_RX, rd);
    check(rd == 32'h3C, "R9 active-high select slave word", rd, 32'h3C);
    hwrite(A_CFG, cfgw(0, 0, 8, 0, 0, 0, 0, 0, 0));
    spi_cs = 1'b1;

    // R8 transmit only
    hwrite(A_TX, 32'hE7);
    hwrite(A_CFG, cfgw(1, 1, 8, 0, 0, 0, 0, 0, 0));
    xfer(32'h11, 8, 0, 0, 0, 0, mi);
    check(mi == 32'hE7, "R8 transmit-only word out", mi, 32'hE7);
    hread(A_STAT, rd);
    check(rd == 32'h1, "R8 transmit-only leaves receive-full clear", rd, 32'h1);
    // R8 receive only
    hwrite(A_CFG, cfgw(1, 2, 8, 0, 0, 0, 0, 0, 0));
    hwrite(A_TX, 32'h55);
    oe0 = oe_cnt;
    xfer(32'hB4, 8, 0, 0, 0, 0, mi);
    hread(A_STAT, rd);
    check(rd == 32'h2, "R8 receive-only keeps transmit-empty clear", rd, 32'h2);
    check(oe_cnt == oe0, "R8 receive-only output enable low", oe_cnt, oe0);
    hread(A_RX, rd);
    check(rd == 32'hB4, "R8 receive-only word in", rd, 32'hB4);

    // R11 back-to-back words
    hwrite(A_CFG, cfgw(0, 0, 8, 0, 0, 0, 0, 0, 0));
    hwrite(A_TX, 32'hA1);
    hwrite(A_CFG, cfgw(1, 0, 8, 0, 0, 0, 0, 0, 0));
    spi_cs = 1'b0;
    repeat (6) @(negedge clk);
    hwrite(A_TX, 32'h7E);
    spi_word(32'h33, 8, 0, 0, 0, mi);
    spi_word(32'hCC, 8, 0, 0, 0, mi2);
    repeat (H) @(negedge clk);
    spi_cs = 1'b1;
    repeat (6) @(negedge clk);
    check(mi == 32'hA1, "R11 first gapless word", mi, 32'hA1);
    check(mi2 == 32'h7E, "R11 second gapless word", mi2, 32'h7E);
    hread(A_RX, rd);
    check(rd == 32'hCC, "R11 last received word", rd, 32'hCC);

    // R10 free-running framing, select held inactive
    hwrite(A_CFG, cfgw(0, 0, 8, 0, 0, 0, 1, 0, 0));
    hwrite(A_TX, 32'h69);
    hwrite(A_CFG, cfgw(1, 0, 8, 0, 0, 0, 1, 0, 0));
    repeat (6) @(negedge clk);
    spi_word(32'hD2, 8, 0, 0, 0, mi);
    repeat (H) @(negedge clk);
    check(mi == 32'h69, "R10 word out without select", mi, 32'h69);
    hread(A_RX, rd);
    check(rd == 32'hD2, "R10 word in without select", rd, 32'hD2);
    hwrite(A_CFG, cfgw(0, 0, 8, 0, 0, 0, 0, 0, 0));

    // R13 select released mid-word
    hwrite(A_TX, 32'h4B);
    hwrite(A_CFG, cfgw(1, 0, 8, 0, 0, 0, 0, 0, 0));
    xfer(32'h7, 3, 0, 0, 0, 0, mi);
    hread(A_STAT, rd);
    check(rd[1] == 1'b0, "R13 partial word not stored", rd, 32'h1);
    xfer(32'h9C, 8, 0, 0, 0, 0, mi);
    check(mi == 32'h4B, "R13 full word after abort out", mi, 32'h4B);
    hread(A_RX, rd);
    check(rd == 32'h9C, "R13 full word after abort in", rd, 32'h9C);

    // R12 DMA requests
    check(dma_wr_req == 1'b0, "R12 write request off while disabled", dma_wr_req, 0);
    hwrite(A_CFG, cfgw(1, 0, 8, 0, 0, 0, 0, 1, 1));
    check(dma_wr_req == 1'b1, "R12 write request follows empty", dma_wr_req, 1);
    hwrite(A_TX, 32'h18);
    check(dma_wr_req == 1'b0, "R12 write request drops after write", dma_wr_req, 0);
    xfer(32'h81, 8, 0, 0, 0, 0, mi);
    check({dma_rd_req, dma_wr_req} == 2'b11, "R12 both requests after word",
          {dma_rd_req, dma_wr_req}, 2'b11);
    hread(A_RX, rd);
    check(dma_rd_req == 1'b0, "R12 read request drops after read", dma_rd_req, 0);

    // R14 completion and host read in the same cycle
    xfer(32'h2D, 8, 0, 0, 0, 0, mi);
    xfer(32'hF0, 8, 0, 0, 0, 1, mi);
    check(coll_data == 32'h2D, "R14 colliding read returns old word", coll_data, 32'h2D);
    hread(A_STAT, rd);
    check(rd[1] == 1'b1, "R14 receive-full survives collision", rd, 32'h3);
    hread(A_RX, rd);
    check(rd == 32'hF0, "R14 new word kept", rd, 32'hF0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule